// File: doc/BRIEF.md
# Flash Burst-Program Command Sequencer

This block sits between a processor's register bus and a flash array. Software stages a target address and data byte, writes a command code, then launches the command by writing a 1 to the buffer-empty flag. The command waits in a one-entry buffer until the execution engine takes it. The engine raises the high-voltage pump enable, waits for the pump to settle, and pulses a program strobe with the address and data. It then counts out the program time and lowers the pump again, which costs a second settling period.

Burst programming avoids the two settling periods on back-to-back writes. The engine checks two things when a burst write finishes: whether the next burst command is already in the buffer, and whether that command targets the same 64-byte row. If both hold, the pump stays on and the next strobe follows with no settling time. Otherwise the pump drops as it does for a standard write. All durations are counted in ticks of a clock divider, and that divider must be written before any command is accepted. Access errors and protection violations block all command traffic until software clears them.

Top module: `flash_burst_seq`

## Requirements
- R1: After reset, flg_buf_empty and flg_done are 1, while flg_acc_err, flg_prot_viol, pump_en and pgm_stb are 0.
- R2: Until the divider has been written (bus_sel 0, value in bus_wdata[DIV_W-1:0], tick period value+1 cycles), an address/data write (bus_sel 1) sets flg_acc_err and nothing is buffered.
- R3: While flg_acc_err or flg_prot_viol is 1, address/data, command and launch writes have no effect. Writing bus_sel 3 with bit 4 set clears flg_acc_err, and with bit 5 set clears flg_prot_viol.
- R4: A launch (bus_sel 3, bit 7 = 1) after an address/data write and a valid command write (bus_sel 2, 8'h01 standard, 8'h02 burst) runs one write. pump_en rises 1 cycle after the launch edge. pgm_stb pulses RAMP_TICKS ticks later, carrying the staged address and data. pump_en falls PGM_TICKS ticks after the strobe.
- R5: When a burst write ends and the buffer already holds a burst command for the same row (address bits above bit 5 equal), pump_en stays 1 and the next strobe comes exactly PGM_TICKS ticks after the previous one.
- R6: A queued burst whose address starts a new row (bits 5..0 zero after a row ending at 6'h3F) causes pump_en to fall and rise again, even though the addresses are consecutive.
- R7: A burst command launched only after the previous burst has finished gets its own pump ramp-up and ramp-down.
- R8: A standard write always lowers pump_en at its end, even when another command is queued.
- R9: A command write without a preceding address/data write, a launch without a preceding command write, or a launch while the buffer is still occupied sets flg_acc_err. It also discards the staged command, so a later command write is again out of order.
- R10: A launch whose address is at or above PROT_BASE sets flg_prot_viol and is not executed.
- R11: flg_buf_empty drops at the launch edge and sets again when the engine takes the command. flg_done is 1 only when the buffer is empty and the engine is idle, and is 0 from the launch until FALL_TICKS ticks after the pump falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 2 | Write target: 0 divider, 1 address/data, 2 command, 3 flags |
| bus_addr | input | ADDR_W | Flash address for an address/data write |
| bus_wdata | input | DATA_W | Write data |
| flg_buf_empty | output | 1 | Command buffer is free |
| flg_done | output | 1 | Buffer empty and no operation active |
| flg_acc_err | output | 1 | Access error |
| flg_prot_viol | output | 1 | Protection violation |
| pump_en | output | 1 | High-voltage pump enable |
| pgm_stb | output | 1 | One-cycle program strobe to the array |
| pgm_addr | output | ADDR_W | Program address |
| pgm_data | output | DATA_W | Program data |

## Verification
The bench uses a divider value of 0, so one tick is one cycle. With that setting, a launch edge clears flg_buf_empty at once, pump_en follows 1 cycle later, the strobe 3 cycles after the launch, the pump fall 7 cycles after, and flg_done 9 cycles after. The bench samples on each falling edge, in the cycle window counted from the launch write. Flag-write results are read on the falling edge just after the write's rising edge. Strobe spacing is measured from cycle stamps that the scoreboard monitor records. Pump hold or drop is judged from a count of pump rising edges, read once flg_done is high.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    localparam logic [1:0] SEL_DIV   = 2'd0;
    localparam logic [1:0] SEL_ARRAY = 2'd1;
    localparam logic [1:0] SEL_CMD   = 2'd2;
    localparam logic [1:0] SEL_FLAG  = 2'd3;

    localparam logic [7:0] CMD_PROG  = 8'h01;
    localparam logic [7:0] CMD_BURST = 8'h02;

    localparam int BIT_LAUNCH = 7;
    localparam int BIT_PVIOL  = 5;
    localparam int BIT_ACCERR = 4;

    typedef enum logic [1:0] {STG_IDLE, STG_ADDR, STG_CMD} stage_e;
    typedef enum logic [1:0] {ENG_IDLE, ENG_RAMP, ENG_PROG, ENG_FALL} eng_e;
endpackage

// File: rtl/fbs_tick_gen.sv
module fbs_tick_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } st_t;

    st_t q, d;

    always_comb begin
        d = q;
        tick_o = (q.cnt >= div_i);
        d.cnt = tick_o ? '0 : q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4
    tick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (q.cnt == '0));
endmodule

// File: rtl/fbs_front.sv
module fbs_front
    import fbs_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              DIV_W     = 6,
    parameter logic [ADDR_W-1:0] PROT_BASE = 'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              take_i,
    output logic [DIV_W-1:0]  div_o,
    output logic              buf_valid_o,
    output logic [ADDR_W-1:0] buf_addr_o,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              buf_burst_o,
    output logic              acc_err_o,
    output logic              pviol_o
);
    typedef struct packed {
        logic              div_set;
        logic [DIV_W-1:0]  div;
        stage_e            stage;
        logic [ADDR_W-1:0] stg_addr;
        logic [DATA_W-1:0] stg_data;
        logic              stg_burst;
        logic              buf_valid;
        logic [ADDR_W-1:0] buf_addr;
        logic [DATA_W-1:0] buf_data;
        logic              buf_burst;
        logic              acc_err;
        logic              pviol;
    } st_t;

    st_t  q, d;
    logic errs;
    logic cmd_ok;

    always_comb begin
        d      = q;
        errs   = q.acc_err | q.pviol;
        cmd_ok = (bus_wdata == DATA_W'(CMD_PROG)) || (bus_wdata == DATA_W'(CMD_BURST));
        if (take_i) d.buf_valid = 1'b0;
        if (bus_we) begin
            case (bus_sel)
                SEL_DIV: begin
                    d.div     = bus_wdata[DIV_W-1:0];
                    d.div_set = 1'b1;
                end
                SEL_ARRAY: if (!errs) begin
                    if (!q.div_set || q.stage != STG_IDLE) begin
                        d.acc_err = 1'b1;
                        d.stage   = STG_IDLE;
                    end else begin
                        d.stg_addr = bus_addr;
                        d.stg_data = bus_wdata;
                        d.stage    = STG_ADDR;
                    end
                end
                SEL_CMD: if (!errs) begin
                    if (q.stage != STG_ADDR || !cmd_ok) begin
                        d.acc_err = 1'b1;
                        d.stage   = STG_IDLE;
                    end else begin
                        d.stg_burst = (bus_wdata == DATA_W'(CMD_BURST));
                        d.stage     = STG_CMD;
                    end
                end
                default: begin
                    if (bus_wdata[BIT_ACCERR]) d.acc_err = 1'b0;
                    if (bus_wdata[BIT_PVIOL])  d.pviol   = 1'b0;
                    if (bus_wdata[BIT_LAUNCH] && !errs) begin
                        d.stage = STG_IDLE;
                        if (q.stage != STG_CMD || (q.buf_valid && !take_i)) begin
                            d.acc_err = 1'b1;
                        end else if (q.stg_addr >= PROT_BASE) begin
                            d.pviol = 1'b1;
                        end else begin
                            d.buf_valid = 1'b1;
                            d.buf_addr  = q.stg_addr;
                            d.buf_data  = q.stg_data;
                            d.buf_burst = q.stg_burst;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign div_o       = q.div;
    assign buf_valid_o = q.buf_valid;
    assign buf_addr_o  = q.buf_addr;
    assign buf_data_o  = q.buf_data;
    assign buf_burst_o = q.buf_burst;
    assign acc_err_o   = q.acc_err;
    assign pviol_o     = q.pviol;

    // R2
    no_div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q.div_set |-> (q.stage == STG_IDLE && !q.buf_valid));
    // R3
    err_blocks_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.acc_err || q.pviol) |=> !$rose(q.buf_valid));
    // R9
    acc_err_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.acc_err) |-> (q.stage == STG_IDLE));
    // R10
    pviol_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pviol) |-> !$rose(q.buf_valid));
endmodule

// File: rtl/fbs_engine.sv
module fbs_engine
    import fbs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter int ROW_BITS   = 6,
    parameter int PGM_TICKS  = 4,
    parameter int RAMP_TICKS = 2,
    parameter int FALL_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              buf_valid_i,
    input  logic [ADDR_W-1:0] buf_addr_i,
    input  logic [DATA_W-1:0] buf_data_i,
    input  logic              buf_burst_i,
    output logic              take_o,
    output logic              busy_o,
    output logic              pump_o,
    output logic              stb_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam int MAX_A = (PGM_TICKS > RAMP_TICKS) ? PGM_TICKS : RAMP_TICKS;
    localparam int MAX_T = (MAX_A > FALL_TICKS) ? MAX_A : FALL_TICKS;
    localparam int CNT_W = $clog2(MAX_T + 1);

    typedef struct packed {
        eng_e              state;
        logic [CNT_W-1:0]  cnt;
        logic              pump;
        logic              stb;
        logic              burst;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } st_t;

    st_t  q, d;
    logic same_row;
    logic last;

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        take_o   = 1'b0;
        same_row = (buf_addr_i[ADDR_W-1:ROW_BITS] == q.addr[ADDR_W-1:ROW_BITS]);
        last     = tick_i && (q.cnt == CNT_W'(1));
        case (q.state)
            ENG_IDLE: if (buf_valid_i) begin
                take_o  = 1'b1;
                d.addr  = buf_addr_i;
                d.data  = buf_data_i;
                d.burst = buf_burst_i;
                d.pump  = 1'b1;
                d.cnt   = CNT_W'(RAMP_TICKS);
                d.state = ENG_RAMP;
            end
            ENG_RAMP: if (tick_i) begin
                if (last) begin
                    d.state = ENG_PROG;
                    d.cnt   = CNT_W'(PGM_TICKS);
                    d.stb   = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ENG_PROG: if (tick_i) begin
                if (last) begin
                    if (q.burst && buf_valid_i && buf_burst_i && same_row) begin
                        take_o = 1'b1;
                        d.addr = buf_addr_i;
                        d.data = buf_data_i;
                        d.cnt  = CNT_W'(PGM_TICKS);
                        d.stb  = 1'b1;
                    end else begin
                        d.pump  = 1'b0;
                        d.cnt   = CNT_W'(FALL_TICKS);
                        d.state = ENG_FALL;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: if (tick_i) begin
                if (last) d.state = ENG_IDLE;
                else      d.cnt   = q.cnt - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = (q.state != ENG_IDLE);
    assign pump_o = q.pump;
    assign stb_o  = q.stb;
    assign addr_o = q.addr;
    assign data_o = q.data;

    // R4
    stb_needs_pump_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |-> q.pump);
    // R7
    pump_fall_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.pump) |-> ($past(q.state) == ENG_PROG));
    // R8
    std_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ENG_PROG && !q.burst && last) |=> !q.pump);
    // R5
    chain_same_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stb && $past(q.state) == ENG_PROG) |->
        (q.addr[ADDR_W-1:ROW_BITS] == $past(q.addr[ADDR_W-1:ROW_BITS])));
endmodule

// File: rtl/flash_burst_seq.sv
module flash_burst_seq #(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                DIV_W      = 6,
    parameter int                ROW_BITS   = 6,
    parameter int                PGM_TICKS  = 4,
    parameter int                RAMP_TICKS = 2,
    parameter int                FALL_TICKS = 2,
    parameter logic [ADDR_W-1:0] PROT_BASE  = 'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              flg_buf_empty,
    output logic              flg_done,
    output logic              flg_acc_err,
    output logic              flg_prot_viol,
    output logic              pump_en,
    output logic              pgm_stb,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [DATA_W-1:0] pgm_data
);
    logic [DIV_W-1:0]  div;
    logic              tick;
    logic              take;
    logic              busy;
    logic              buf_valid;
    logic [ADDR_W-1:0] buf_addr;
    logic [DATA_W-1:0] buf_data;
    logic              buf_burst;

    fbs_tick_gen #(.DIV_W(DIV_W)) i_tick (
        .clk(clk), .rst_n(rst_n), .div_i(div), .tick_o(tick)
    );

    fbs_front #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIV_W(DIV_W), .PROT_BASE(PROT_BASE)
    ) i_front (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .take_i(take),
        .div_o(div), .buf_valid_o(buf_valid), .buf_addr_o(buf_addr),
        .buf_data_o(buf_data), .buf_burst_o(buf_burst),
        .acc_err_o(flg_acc_err), .pviol_o(flg_prot_viol)
    );

    fbs_engine #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROW_BITS(ROW_BITS),
        .PGM_TICKS(PGM_TICKS), .RAMP_TICKS(RAMP_TICKS), .FALL_TICKS(FALL_TICKS)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .buf_valid_i(buf_valid),
        .buf_addr_i(buf_addr), .buf_data_i(buf_data), .buf_burst_i(buf_burst),
        .take_o(take), .busy_o(busy), .pump_o(pump_en), .stb_o(pgm_stb),
        .addr_o(pgm_addr), .data_o(pgm_data)
    );

    assign flg_buf_empty = !buf_valid;
    assign flg_done      = !buf_valid && !busy;

    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_done |-> !pgm_stb);
endmodule

// File: tb/test_flash_burst_seq.sv
module test_flash_burst_seq;
    localparam int PGM  = 4;
    localparam int RAMP = 2;
    localparam int FALL = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [15:0] bus_addr = 16'h0;
    logic [7:0]  bus_wdata = 8'h0;
    logic        flg_buf_empty, flg_done, flg_acc_err, flg_prot_viol;
    logic        pump_en, pgm_stb;
    logic [15:0] pgm_addr;
    logic [7:0]  pgm_data;

    always #2 clk = ~clk;

    flash_burst_seq #(
        .ADDR_W(16), .DATA_W(8), .DIV_W(6), .ROW_BITS(6),
        .PGM_TICKS(PGM), .RAMP_TICKS(RAMP), .FALL_TICKS(FALL), .PROT_BASE(16'hF000)
    ) i_flash_burst_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .flg_buf_empty(flg_buf_empty), .flg_done(flg_done),
        .flg_acc_err(flg_acc_err), .flg_prot_viol(flg_prot_viol),
        .pump_en(pump_en), .pgm_stb(pgm_stb), .pgm_addr(pgm_addr), .pgm_data(pgm_data)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rises = 0;
    int stb_cnt = 0;
    logic pump_prev = 1'b0;
    logic [23:0] expq[$];
    int stamps[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: scoreboard pop and compare, pump rise counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (pump_en && !pump_prev) rises++;
            pump_prev = pump_en;
            if (pgm_stb) begin
                stb_cnt++;
                stamps.push_back(cyc);
                if (expq.size() == 0) begin
                    chk(0, "R4", "unexpected strobe addr", int'(pgm_addr), 0);
                end else begin
                    logic [23:0] e;
                    e = expq.pop_front();
                    chk(pgm_addr == e[23:8], "R4", "strobe address", int'(pgm_addr), int'(e[23:8]));
                    chk(pgm_data == e[7:0], "R4", "strobe data", int'(pgm_data), int'(e[7:0]));
                end
            end
        end
    end

    task automatic push_exp(input logic [15:0] a, input logic [7:0] dt);
        expq.push_back({a, dt});
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [15:0] a, input logic [7:0] dt);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_addr = a; bus_wdata = dt;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic launch_poll();
        @(negedge clk);
        while (!flg_buf_empty) @(negedge clk);
        bus_we = 1'b1; bus_sel = 2'd3; bus_addr = 16'h0; bus_wdata = 8'h80;
        @(posedge clk);
        #1 bus_we = 1'b0;
    endtask

    task automatic stage(input logic [15:0] a, input logic [7:0] dt, input logic [7:0] cmd);
        bus_write(2'd1, a, dt);
        bus_write(2'd2, 16'h0, cmd);
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!flg_done) @(negedge clk);
        @(posedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r0;
        int s0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(flg_buf_empty == 1, "R1", "buf_empty", flg_buf_empty, 1);
        chk(flg_done == 1, "R1", "done", flg_done, 1);
        chk(flg_acc_err == 0, "R1", "acc_err", flg_acc_err, 0);
        chk(flg_prot_viol == 0, "R1", "prot_viol", flg_prot_viol, 0);
        chk(pump_en == 0, "R1", "pump_en", pump_en, 0);
        chk(pgm_stb == 0, "R1", "pgm_stb", pgm_stb, 0);

        // R2 address write before divider
        bus_write(2'd1, 16'h0010, 8'hAA);
        @(negedge clk);
        chk(flg_acc_err == 1, "R2", "acc_err without divider", flg_acc_err, 1);
        chk(flg_buf_empty == 1, "R2", "nothing buffered", flg_buf_empty, 1);

        // R3 commands ignored while an error is set
        bus_write(2'd0, 16'h0, 8'h00);
        s0 = stb_cnt;
        stage(16'h0020, 8'h11, 8'h01);
        bus_write(2'd3, 16'h0, 8'h80);
        @(negedge clk);
        chk(flg_buf_empty == 1, "R3", "launch ignored under error", flg_buf_empty, 1);
        repeat (12) @(negedge clk);
        chk(stb_cnt == s0, "R3", "no strobe under error", stb_cnt - s0, 0);
        chk(flg_acc_err == 1, "R3", "acc_err stays", flg_acc_err, 1);
        bus_write(2'd3, 16'h0, 8'h10);
        @(negedge clk);
        chk(flg_acc_err == 0, "R3", "acc_err cleared", flg_acc_err, 0);

        // R4 / R11 single standard write timing
        r0 = rises;
        push_exp(16'h0030, 8'h5A);
        stage(16'h0030, 8'h5A, 8'h01);
        bus_write(2'd3, 16'h0, 8'h80);
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            chk(pump_en == (k >= 2 && k <= 7), "R4", $sformatf("pump_en k=%0d", k),
                pump_en, (k >= 2 && k <= 7));
            chk(pgm_stb == (k == 4), "R4", $sformatf("pgm_stb k=%0d", k), pgm_stb, (k == 4));
            chk(flg_done == (k >= 10), "R11", $sformatf("done k=%0d", k), flg_done, (k >= 10));
            chk(flg_buf_empty == (k != 1), "R11", $sformatf("buf_empty k=%0d", k),
                flg_buf_empty, (k != 1));
        end
        @(posedge clk);
        chk(rises - r0 == 1, "R4", "pump rises", rises - r0, 1);

        // R8 standard writes never hold the pump
        r0 = rises; stamps.delete();
        push_exp(16'h0040, 8'h01); push_exp(16'h0041, 8'h02);
        stage(16'h0040, 8'h01, 8'h01);
        bus_write(2'd3, 16'h0, 8'h80);
        stage(16'h0041, 8'h02, 8'h01);
        launch_poll();
        wait_done();
        chk(rises - r0 == 2, "R8", "pump rises", rises - r0, 2);
        chk(stamps.size() == 2 && stamps[1] - stamps[0] == PGM + FALL + 1 + RAMP, "R8",
            "strobe gap", (stamps.size() == 2) ? stamps[1] - stamps[0] : -1, PGM + FALL + 1 + RAMP);

        // R5 chained burst in one row
        r0 = rises; stamps.delete();
        push_exp(16'h0010, 8'hA0); push_exp(16'h0011, 8'hA1); push_exp(16'h0012, 8'hA2);
        stage(16'h0010, 8'hA0, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        stage(16'h0011, 8'hA1, 8'h02);
        launch_poll();
        stage(16'h0012, 8'hA2, 8'h02);
        launch_poll();
        wait_done();
        chk(rises - r0 == 1, "R5", "pump held", rises - r0, 1);
        chk(stamps.size() == 3 && stamps[1] - stamps[0] == PGM, "R5", "gap 1",
            (stamps.size() == 3) ? stamps[1] - stamps[0] : -1, PGM);
        chk(stamps.size() == 3 && stamps[2] - stamps[1] == PGM, "R5", "gap 2",
            (stamps.size() == 3) ? stamps[2] - stamps[1] : -1, PGM);

        // R6 burst across a row edge
        r0 = rises; stamps.delete();
        push_exp(16'h003F, 8'hB0); push_exp(16'h0040, 8'hB1);
        stage(16'h003F, 8'hB0, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        stage(16'h0040, 8'hB1, 8'h02);
        launch_poll();
        wait_done();
        chk(rises - r0 == 2, "R6", "pump re-ramped", rises - r0, 2);
        chk(stamps.size() == 2 && stamps[1] - stamps[0] == PGM + FALL + 1 + RAMP, "R6",
            "strobe gap", (stamps.size() == 2) ? stamps[1] - stamps[0] : -1, PGM + FALL + 1 + RAMP);

        // R7 burst launched too late
        r0 = rises;
        push_exp(16'h0050, 8'hC0); push_exp(16'h0051, 8'hC1);
        stage(16'h0050, 8'hC0, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        wait_done();
        stage(16'h0051, 8'hC1, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        wait_done();
        chk(rises - r0 == 2, "R7", "pump rises", rises - r0, 2);

        // R9 launch while buffer occupied
        r0 = rises;
        push_exp(16'h0080, 8'hD0); push_exp(16'h0081, 8'hD1);
        stage(16'h0080, 8'hD0, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        stage(16'h0081, 8'hD1, 8'h02);
        launch_poll();
        stage(16'h0082, 8'hD2, 8'h02);
        bus_write(2'd3, 16'h0, 8'h80);
        @(negedge clk);
        chk(flg_acc_err == 1, "R9", "launch into full buffer", flg_acc_err, 1);
        wait_done();
        chk(rises - r0 == 1, "R9", "queued burst still chained", rises - r0, 1);
        bus_write(2'd3, 16'h0, 8'h10);
        // R9 command without address
        bus_write(2'd2, 16'h0, 8'h02);
        @(negedge clk);
        chk(flg_acc_err == 1, "R9", "command out of order", flg_acc_err, 1);
        bus_write(2'd3, 16'h0, 8'h10);
        // R9 launch without command, then staged entry discarded
        bus_write(2'd1, 16'h0090, 8'hE0);
        bus_write(2'd3, 16'h0, 8'h80);
        @(negedge clk);
        chk(flg_acc_err == 1, "R9", "launch out of order", flg_acc_err, 1);
        bus_write(2'd3, 16'h0, 8'h10);
        bus_write(2'd2, 16'h0, 8'h01);
        @(negedge clk);
        chk(flg_acc_err == 1, "R9", "staging discarded", flg_acc_err, 1);
        bus_write(2'd3, 16'h0, 8'h10);
        @(negedge clk);
        chk(flg_acc_err == 0, "R9", "acc_err cleared", flg_acc_err, 0);

        // R10 protected address
        s0 = stb_cnt;
        stage(16'hF010, 8'h77, 8'h01);
        bus_write(2'd3, 16'h0, 8'h80);
        @(negedge clk);
        chk(flg_prot_viol == 1, "R10", "prot_viol set", flg_prot_viol, 1);
        chk(flg_buf_empty == 1, "R10", "not buffered", flg_buf_empty, 1);
        repeat (12) @(negedge clk);
        chk(stb_cnt == s0, "R10", "not executed", stb_cnt - s0, 0);
        bus_write(2'd3, 16'h0, 8'h20);
        @(negedge clk);
        chk(flg_prot_viol == 0, "R10", "prot_viol cleared", flg_prot_viol, 0);

        chk(expq.size() == 0, "R4", "pending expected strobes", expq.size(), 0);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule